// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines and presents the most urgent one to a processor. Each line is latched on a rising edge and held while the line stays high. The highest-priority pending line that is not masked and not blocked by service already in progress drives a single interrupt output. Software controls the block through a byte-wide host port with two registers, selected by one address bit. It sets the block up with a short sequence of initialization words. After that it uses command words to poll for the winning line, to choose which status register it reads, and to signal end of service. A mask register blocks individual lines.

A parameter sets the instance as a master or a slave, so two instances can be chained. The slave's interrupt output drives line 2 of the master. The master then flags that the vector for that line belongs to the slave. The slave reports the identity it was given during setup. Software acknowledges a chained interrupt by polling both units. It then sends one end-of-service command to the slave and one to the master.

Top module: `pic8_ctrl`

## Requirements
- R1: When no initialization is in progress, a write with `addr`=1 loads the mask register, and a read with `addr`=1 returns it. Mask bit n set keeps line n from being granted.
- R2: A write with `addr`=0 and data bit 4 set clears the mask, in-service and request registers and starts initialization. Bit 1 of that word means no cascade word follows, and bit 0 means a mode word follows. The next `addr`=1 writes load, in order, the vector base, the cascade word (unless skipped) and the mode word (if requested). `irq_out` stays low until the last expected word has been written.
- R3: A rising edge on `irq_in[n]` sets request bit n. The bit clears when the line goes low or when the request is acknowledged.
- R4: Priority is fixed, with line 0 highest. A request is granted only if it is unmasked and no in-service bit of equal or higher priority (equal or lower index) is set.
- R5: `irq_out` is high exactly when initialization is complete and a grantable request exists.
- R6: Writing 0x0C with `addr`=0 arms a poll. The next `addr`=0 read returns 0x80 plus the granted level, sets that in-service bit and clears that request bit.
- R7: If an armed poll read finds no grantable request, it returns 0x07, and the in-service register is unchanged.
- R8: An `addr`=0 write with bits 4:3 = 01 and bit 1 set selects the status read: bit 0 = 1 selects the in-service register (0x0B), and bit 0 = 0 selects the request register (0x0A). The choice persists. Reset and initialization select the request register.
- R9: An `addr`=0 write with bits 4:3 = 00 and bits 7:5 = 001 (0x20) clears the lowest-index set in-service bit. Other codes of that form, such as 0x60, leave the in-service register unchanged.
- R10: When mode word bit 0 is 1, `vec_out` equals the vector base plus the granted level. When it is 0, `vec_out` is 0x00.
- R11: In a master, `vec_from_slave` is high when a granted level has its cascade-word bit set. In a slave, `cas_id` equals cascade-word bits 2:0. A master's `cas_id` is 0.
- R12: After reset, the mask is 0xFF, the request and in-service registers are 0, `irq_out` is low, and initialization is not complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; an armed poll is consumed by an `addr`=0 read |
| addr | input | 1 | Register select: 0 command/status, 1 data/mask |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| irq_out | output | 1 | Grantable request present |
| vec_out | output | 8 | Vector byte for the granted level |
| vec_from_slave | output | 1 | Master only: granted level is a cascaded line |
| cas_id | output | 3 | Slave identity from the cascade word |

## Verification
The bench drops a line before the poll to check spurious handling. A design that set in-service bit 7 here, or returned a valid flag, would block every lower line or send software to a handler that does not exist. It polls while an in-service bit blocks a lower line and checks that the lower line is held back; a priority check that ignored in-service state would nest interrupts of equal or lower rank. It re-initializes the block with edges pending and with the cascade word skipped. A design that kept old mask or in-service state, or consumed the wrong number of setup words, would write the mask into the wrong register. A chained pair checks the cascade flag, the slave identity and the two end-of-service commands.

// File: rtl/pic8_ctrl.sv
module pic8_ctrl #(
  parameter bit MASTER = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       irq_out,
  output logic [7:0] vec_out,
  output logic       vec_from_slave,
  output logic [2:0] cas_id
);
  localparam int NL = 8;
  localparam int LW = $clog2(NL);

  typedef enum logic [1:0] {ST_RUN, ST_BASE, ST_CAS, ST_MODE} step_t;

  logic [NL-1:0] irr, imr, isr, prev;
  logic [7:0]    base, cas;
  logic          sel_isr, poll, ready, single, need4, m86;
  step_t         step;

  logic [LW:0] req_lvl, isr_lvl;
  wire  [NL-1:0] req = irr & ~imr;

  always_comb begin
    req_lvl = LW'(0) + (LW+1)'(NL);
    isr_lvl = LW'(0) + (LW+1)'(NL);
    for (int i = NL-1; i >= 0; i--) begin
      if (req[i]) req_lvl = (LW+1)'(i);
      if (isr[i]) isr_lvl = (LW+1)'(i);
    end
  end

  wire [LW-1:0] lvl     = req_lvl[LW-1:0];
  wire          grant   = ready && (req_lvl < isr_lvl);
  wire          wr_cmd  = wr_en && !addr;
  wire          wr_dat  = wr_en && addr;
  wire          is_init = wr_cmd && wdata[4];
  wire          is_ocw3 = wr_cmd && !wdata[4] && wdata[3];
  wire          is_eoi  = wr_cmd && !wdata[4] && !wdata[3] && (wdata[7:5] == 3'b001);
  wire          poll_rd = rd_en && !addr && poll;
  wire          ack     = poll_rd && grant;
  wire [NL-1:0] lvl_bit = NL'(1) << lvl;
  wire [NL-1:0] isr_low = isr & (~isr + NL'(1));

  assign irq_out        = grant;
  assign vec_out        = m86 ? base + 8'(lvl) : 8'h00;
  assign vec_from_slave = MASTER && grant && cas[lvl];
  assign cas_id         = MASTER ? 3'd0 : cas[2:0];

  always_comb begin
    if (addr)         rdata = imr;
    else if (poll)    rdata = grant ? {1'b1, 4'b0000, lvl} : 8'h07;
    else if (sel_isr) rdata = isr;
    else              rdata = irr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0; imr <= '1; isr <= '0; prev <= '0;
      base <= '0; cas <= '0;
      sel_isr <= 1'b0; poll <= 1'b0; ready <= 1'b0;
      single <= 1'b0; need4 <= 1'b0; m86 <= 1'b0;
      step <= ST_RUN;
    end else begin
      prev <= irq_in;
      if (is_init) begin
        irr <= '0; imr <= '0; isr <= '0; cas <= '0;
        sel_isr <= 1'b0; poll <= 1'b0; ready <= 1'b0; m86 <= 1'b0;
        single <= wdata[1];
        need4  <= wdata[0];
        step   <= ST_BASE;
      end else begin
        irr <= ((irr | (irq_in & ~prev)) & irq_in) & ~(ack ? lvl_bit : '0);
        if (ack)         isr <= isr | lvl_bit;
        else if (is_eoi) isr <= isr & ~isr_low;
        if (poll_rd)                   poll <= 1'b0;
        else if (is_ocw3 && wdata[2])  poll <= 1'b1;
        if (is_ocw3 && wdata[1]) sel_isr <= wdata[0];
        if (wr_dat) begin
          case (step)
            ST_RUN:  imr <= wdata;
            ST_BASE: begin
              base  <= wdata;
              step  <= !single ? ST_CAS : (need4 ? ST_MODE : ST_RUN);
              ready <= single && !need4;
            end
            ST_CAS: begin
              cas   <= wdata;
              step  <= need4 ? ST_MODE : ST_RUN;
              ready <= !need4;
            end
            default: begin
              m86   <= wdata[0];
              step  <= ST_RUN;
              ready <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  p_mask_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && step == ST_RUN) |=> imr == $past(wdata));

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_init |=> (imr == '0 && isr == '0 && !irq_out));

  p_grant_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (irr[lvl] && !imr[lvl] && !(|(isr & ((lvl_bit << 1) - NL'(1))))));

  p_ack_sets_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> $countones(isr) == $past($countones(isr)) + 1);

  p_spurious_keeps_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_rd && !grant) |=> $stable(isr));

  p_eoi_drops_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_eoi && isr != '0) |=> $countones(isr) + 1 == $past($countones(isr)));
endmodule

// File: tb/tb_pic8_ctrl.sv
module tb_pic8_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic wr_d = 0, rden_d = 0, wr_m = 0, rden_m = 0, wr_s = 0, rden_s = 0;
  logic [7:0] lines = '0, lines_s = '0;
  logic [7:0] rdat_d, rdat_m, rdat_s, vec_d, vec_m, vec_s;
  logic irq_d, irq_m, irq_s, vfs_d, vfs_m, vfs_s;
  logic [2:0] cid_d, cid_m, cid_s;

  pic8_ctrl #(.MASTER(1'b1)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_d), .rd_en(rden_d),
    .addr(addr), .wdata(wdata), .rdata(rdat_d), .irq_in(lines), .irq_out(irq_d),
    .vec_out(vec_d), .vec_from_slave(vfs_d), .cas_id(cid_d));
  pic8_ctrl #(.MASTER(1'b1)) cm (.clk(clk), .rst_n(rst_n), .wr_en(wr_m), .rd_en(rden_m),
    .addr(addr), .wdata(wdata), .rdata(rdat_m), .irq_in({5'b0, irq_s, 2'b0}), .irq_out(irq_m),
    .vec_out(vec_m), .vec_from_slave(vfs_m), .cas_id(cid_m));
  pic8_ctrl #(.MASTER(1'b0)) cs (.clk(clk), .rst_n(rst_n), .wr_en(wr_s), .rd_en(rden_s),
    .addr(addr), .wdata(wdata), .rdata(rdat_s), .irq_in(lines_s), .irq_out(irq_s),
    .vec_out(vec_s), .vec_from_slave(vfs_s), .cas_id(cid_s));

  int checks = 0, errors = 0;

  // reference model of the single controller, built from the requirements
  logic [7:0] m_irr = '0, m_mask = 8'hFF, m_isr = '0, m_prev = '0, m_base = '0;
  bit m_sel = 0, m_poll = 0, m_ready = 0, m_single = 0, m_need4 = 0, m_m86 = 0;
  int m_step = 0;

  function automatic int low_idx(input logic [7:0] v);
    int r = 8;
    for (int i = 7; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  function automatic bit m_grant();
    return m_ready && (low_idx(m_irr & ~m_mask) < low_idx(m_isr));
  endfunction

  function automatic logic [7:0] m_read(input bit a);
    if (a) return m_mask;
    if (m_poll) return m_grant() ? (8'h80 | 8'(low_idx(m_irr & ~m_mask))) : 8'h07;
    return m_sel ? m_isr : m_irr;
  endfunction

  task automatic m_edge(input bit wr, input bit rd, input bit a, input logic [7:0] d, input logic [7:0] in);
    logic [7:0] nirr;
    int lv = low_idx(m_irr & ~m_mask);
    bit g = m_grant();
    nirr = (m_irr | (in & ~m_prev)) & in;
    if (rd && !a && m_poll) begin
      m_poll = 0;
      if (g) begin m_isr[lv] = 1'b1; nirr[lv] = 1'b0; end
    end
    if (wr && !a) begin
      if (d[4]) begin
        nirr = '0; m_mask = '0; m_isr = '0; m_sel = 0; m_poll = 0; m_ready = 0; m_m86 = 0;
        m_single = d[1]; m_need4 = d[0]; m_step = 1;
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_sel = d[0];
      end else if (d[7:5] == 3'b001 && m_isr != 0) m_isr[low_idx(m_isr)] = 1'b0;
    end else if (wr && a) begin
      case (m_step)
        0: m_mask = d;
        1: begin m_base = d; m_step = !m_single ? 2 : (m_need4 ? 3 : 0); m_ready = (m_step == 0); end
        2: begin m_step = m_need4 ? 3 : 0; m_ready = (m_step == 0); end
        default: begin m_m86 = d[0]; m_step = 0; m_ready = 1; end
      endcase
    end
    m_irr = nirr;
    m_prev = in;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int tgt, input bit wr, input bit rd, input bit a, input logic [7:0] d,
                     output logic [7:0] rv);
    @(negedge clk);
    addr = a; wdata = d;
    wr_d = (tgt == 0) && wr; rden_d = (tgt == 0) && rd;
    wr_m = (tgt == 1) && wr; rden_m = (tgt == 1) && rd;
    wr_s = (tgt == 2) && wr; rden_s = (tgt == 2) && rd;
    #1;
    rv = (tgt == 0) ? rdat_d : (tgt == 1) ? rdat_m : rdat_s;
    m_edge((tgt == 0) && wr, (tgt == 0) && rd, a, d, lines);
    @(posedge clk); #1;
    wr_d = 0; rden_d = 0; wr_m = 0; rden_m = 0; wr_s = 0; rden_s = 0;
  endtask

  task automatic wr8(input int tgt, input bit a, input logic [7:0] d);
    logic [7:0] dummy;
    cyc(tgt, 1, 0, a, d, dummy);
  endtask

  task automatic rd8(input int tgt, input bit a, output logic [7:0] rv);
    cyc(tgt, 0, 1, a, 8'h00, rv);
  endtask

  task automatic idle(input int n);
    logic [7:0] dummy;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 8'h00, dummy);
  endtask

  task automatic rd_chk(input string tag, input bit a);
    logic [7:0] exp, got;
    exp = m_read(a);
    rd8(0, a, got);
    chk(tag, got, exp);
  endtask

  task automatic out_chk(input string tag);
    chk({tag, " irq_out"}, irq_d, m_grant());
    if (m_grant())
      chk({tag, " vec_out"}, vec_d, m_m86 ? m_base + 8'(low_idx(m_irr & ~m_mask)) : 8'h00);
  endtask

  task automatic init4(input int tgt, input logic [7:0] w1, input logic [7:0] b,
                       input logic [7:0] c, input logic [7:0] m);
    wr8(tgt, 0, w1); wr8(tgt, 1, b);
    if (!w1[1]) wr8(tgt, 1, c);
    if (w1[0]) wr8(tgt, 1, m);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    int unsigned seed;
    seed = $urandom(32'd20517);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R12 reset state
    chk("R12 irq_out after reset", irq_d, 0);
    rd_chk("R12 mask after reset", 1);
    rd_chk("R12 request reg after reset", 0);

    // R2 initialization sequence, output quiet until complete
    lines = 8'h10;
    wr8(0, 0, 8'h11);
    rd_chk("R2 mask cleared by init", 1);
    wr8(0, 1, 8'h20);
    chk("R2 quiet during init", irq_d, 0);
    wr8(0, 1, 8'h04);
    chk("R2 quiet during init", irq_d, 0);
    wr8(0, 1, 8'h01);
    out_chk("R2 after init");

    // R3 edge latch and R5/R10 output
    lines = 8'h00; idle(1);
    lines = 8'h10; idle(2);
    out_chk("R3 R5 R10 rising edge");
    chk("R10 vector base+4", vec_d, 8'h24);
    lines = 8'h12; idle(2);
    chk("R4 line1 wins", vec_d, 8'h21);
    wr8(0, 1, 8'h02);
    rd_chk("R1 mask readback", 1);
    chk("R1 masked line skipped", vec_d, 8'h24);

    // R6 poll acknowledge
    wr8(0, 0, 8'h0C);
    rd_chk("R6 poll result", 0);
    lines = 8'h52; idle(2);
    out_chk("R4 lower line held by in-service");
    chk("R4 line6 blocked", irq_d, 0);

    // R8 read select
    wr8(0, 0, 8'h0B);
    rd_chk("R8 isr select", 0);
    rd_chk("R8 isr select persists", 0);
    wr8(0, 0, 8'h0A);
    rd_chk("R8 request select", 0);

    // R9 end of interrupt
    wr8(0, 0, 8'h0B);
    wr8(0, 0, 8'h60);
    rd_chk("R9 other code ignored", 0);
    chk("R9 isr kept", rdat_d, 8'h10);
    wr8(0, 0, 8'h20);
    rd_chk("R9 eoi clears", 0);
    out_chk("R4 line6 after eoi");

    // R7 spurious poll
    lines = 8'h00; idle(1);
    wr8(0, 0, 8'h20);
    lines = 8'h20; idle(2);
    lines = 8'h00; idle(1);
    wr8(0, 0, 8'h0C);
    rd_chk("R7 spurious poll", 0);
    rd_chk("R7 isr unchanged", 0);

    // R2 skipped cascade word and R10 non-8086 mode
    wr8(0, 0, 8'h13);
    wr8(0, 1, 8'h40);
    wr8(0, 1, 8'h00);
    wr8(0, 1, 8'hF0);
    rd_chk("R2 single init mask write", 1);
    lines = 8'h01; idle(2);
    out_chk("R10 non-8086 vector");
    chk("R10 vector zero", vec_d, 8'h00);

    init4(0, 8'h11, 8'h00, 8'h04, 8'h01);
    lines = 8'h00; idle(1);

    // R11 cascaded pair
    init4(1, 8'h11, 8'h00, 8'h04, 8'h01);
    wr8(1, 1, 8'hFB);
    init4(2, 8'h11, 8'h08, 8'h02, 8'h01);
    wr8(2, 1, 8'h00);
    lines_s = 8'h08; idle(3);
    chk("R11 slave irq", irq_s, 1);
    chk("R11 slave vector", vec_s, 8'h0B);
    chk("R11 master irq", irq_m, 1);
    chk("R11 master cascade flag", vfs_m, 1);
    chk("R11 slave id", cid_s, 3'd2);
    chk("R11 master id", cid_m, 3'd0);
    wr8(1, 0, 8'h0C); rd8(1, 0, rv); chk("R11 master poll", rv, 8'h82);
    wr8(2, 0, 8'h0C); rd8(2, 0, rv); chk("R11 slave poll", rv, 8'h83);
    wr8(2, 0, 8'h20); wr8(2, 0, 8'h0B); rd8(2, 0, rv); chk("R11 slave eoi", rv, 8'h00);
    wr8(1, 0, 8'h0B); rd8(1, 0, rv); chk("R11 master isr before eoi", rv, 8'h04);
    wr8(1, 0, 8'h20); rd8(1, 0, rv); chk("R11 master eoi", rv, 8'h00);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r = $urandom_range(0, 11);
      if (r <= 3) begin
        lines = lines ^ (8'h01 << $urandom_range(0, 7));
        idle(1);
      end else if (r == 4) begin
        wr8(0, 0, 8'h0C);
        rd_chk("R6 R7 random poll", 0);
      end else if (r == 5) begin
        wr8(0, 0, 8'h20);
      end else if (r == 6) begin
        wr8(0, 1, 8'($urandom) & 8'($urandom));
        rd_chk("R1 random mask", 1);
      end else if (r == 7) begin
        wr8(0, 0, $urandom_range(0, 1) ? 8'h0B : 8'h0A);
        rd_chk("R8 random status", 0);
      end else if (r == 8 && $urandom_range(0, 15) == 0) begin
        init4(0, 8'h11, 8'($urandom) & 8'hF8, 8'h04, 8'h01);
        rd_chk("R2 random reinit", 1);
      end else begin
        idle(1);
      end
      out_chk("R4 R5 random");
    end

    finish_run();
  end
endmodule